// File: doc/BRIEF.md
# Paired Trace Resource Selector Bank

This block turns a set of live trace resource signals into a small number of Boolean events. Each programmable selector holds a control word. The control word names one resource group, gives a mask of the resources in that group, and carries two inversion bits. A selector is TRUE when any resource that its mask enables is high in the chosen group.

Selectors work in even/odd pairs. A three-bit code, built from the pair-invert bit of the even selector and the invert bits of both selectors, decides how the two selector results combine. The combinations are AND or OR forms with De Morgan inversions. Two codes are reserved.

Configuration goes through a word-addressed debug port. Writes are accepted only while the trace unit reports that it is idle. The comparators, counters and sequencer live outside this block and arrive here as plain input vectors. Selectors 0 and 1 are fixed at FALSE and TRUE, so they need no storage and form no output pair.

Top module: `trsel_bank`

## Requirements
- R1: After reset every control register reads 0 and every bit of `pair_evt` is 0.
- R2: Control register n (2..31) sits at byte address 0x200 + 4n. A write to any other address, including n = 0, n = 1 and misaligned addresses, changes nothing. A read of any other address returns 0. Read data appears on `bus_rdata` one cycle after the address is presented.
- R3: A write stores `bus_wdata[21:0]` and forces bits [31:22] to zero. A later read returns exactly the stored word.
- R4: A write issued while `trace_busy` is 1 is dropped, and the register keeps its old value.
- R5: The control word splits into four fields. Bit 21 is pair-invert, bit 20 is the selector's own invert, bits [19:16] are the group and bits [15:0] are the mask. The group chooses the source and the mask bit m selects bit m of that source: 0 `ext_in`[3:0], 1 `core_cmp`[7:0], 2 counters/sequencer, 3 `shot_ctl`[7:0], 4 `addr_match`[15:0], 5 `range_match`[7:0], 6 `ctx_match`[7:0], 7 `vctx_match`[7:0]. The raw selector value is the OR of the enabled resource bits.
- R6: In group 2, mask bits [3:0] select `cnt_zero`[3:0] and mask bits [7:4] select `seq_state`[3:0].
- R7: Mask bits above the width of the chosen group have no effect, and an all-zero mask gives a raw value of FALSE.
- R8: For a group code from 8 to 15, the raw selector value is FALSE.
- R9: For pair p (selectors 2p and 2p+1, with raw values A and B), the code {even bit 21, even bit 20, odd bit 20} gives the result as follows: 000 gives A&B, 010 gives !A&B, 011 gives !A&!B, 100 gives !A|!B, 101 gives !A|B, 111 gives A|B. Bit 21 of the odd selector is ignored.
- R10: Codes 001 and 110 drive the pair output to 0.
- R11: `pair_evt` is registered. Its value after a rising edge reflects the inputs and the register contents that were present just before that edge.
- R12: `pair_evt[j]` is the result of pair j+1, which uses selectors 2j+2 and 2j+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address for configuration reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| trace_busy | input | 1 | High while the trace unit is not idle; writes are dropped while it is high |
| bus_rdata | output | 32 | Registered read data |
| ext_in | input | 4 | External input resources |
| core_cmp | input | 8 | Processor comparator inputs |
| cnt_zero | input | 4 | Counter-at-zero flags |
| seq_state | input | 4 | Sequencer state flags |
| shot_ctl | input | 8 | Single-shot comparator controls |
| addr_match | input | 16 | Single address comparator hits |
| range_match | input | 8 | Address range comparator hits |
| ctx_match | input | 8 | Context identifier comparator hits |
| vctx_match | input | 8 | Virtual context identifier comparator hits |
| pair_evt | output | 15 | One registered event per selector pair 1..15 |

## Verification
Directed patterns come first. A single resource bit is set and routed through each group, so that a misrouted group or a shifted mask field shows up. The group-2 split is checked bit by bit to catch swapped counter and sequencer halves. All eight pair codes are run against the four combinations of A and B, which separates every AND/OR/inversion form from the reserved ones. Random configurations with random resource vectors then cover all pairs together and reveal pair-index errors and any cross-talk between selectors.

// File: rtl/trsel_pkg.sv
package trsel_pkg;
  localparam int CFG_W  = 22;
  localparam int MASK_W = 16;
  localparam int GRP_W  = 4;
  localparam int NGRP   = 8;
  localparam int GRP_LO = 16;
  localparam int INV_B  = 20;
  localparam int PINV_B = 21;
  localparam int EXT_W  = 4;
  localparam int CMP_W  = 8;
  localparam int CNT_W  = 4;
  localparam int SEQ_W  = 4;
  localparam int SHOT_W = 8;
  localparam int ADR_W  = 16;
  localparam int RNG_W  = 8;
  localparam int CTX_W  = 8;
  localparam int VCTX_W = 8;
  typedef enum logic [2:0] {
    PC_AND    = 3'b000,
    PC_RSV_A  = 3'b001,
    PC_NAANDB = 3'b010,
    PC_NOR    = 3'b011,
    PC_NAND   = 3'b100,
    PC_NAORB  = 3'b101,
    PC_RSV_B  = 3'b110,
    PC_OR     = 3'b111
  } pair_code_e;
endpackage

// File: rtl/trsel_regs.sv
module trsel_regs
  import trsel_pkg::*;
#(
  parameter int NSEL = 32,
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter logic [AW-1:0] BASE = 12'h200
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic                       busy,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  output logic [(NSEL-2)*CFG_W-1:0]  cfg_flat
);
  localparam int IW = $clog2(NSEL);

  logic [CFG_W-1:0] mem [NSEL];
  logic [IW-1:0]    idx;
  logic             hit;

  // word index taken from the address; base must be aligned to the window
  always_comb begin
    idx = addr[IW+1:2];
    hit = (addr[1:0] == 2'b00) && (addr[AW-1:IW+2] == BASE[AW-1:IW+2])
          && (int'(idx) >= 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSEL; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (wr && !busy && hit) mem[idx] <= wdata[CFG_W-1:0];
      rdata <= hit ? {{(DW-CFG_W){1'b0}}, mem[idx]} : '0;
    end
  end

  for (genvar s = 2; s < NSEL; s++) begin : g_out
    assign cfg_flat[(s-2)*CFG_W +: CFG_W] = mem[s];
  end

  assert_busy_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && busy && hit) |=> mem[$past(idx)] == $past(mem[idx]));

  assert_wr_store_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && !busy && hit) |=> mem[$past(idx)] == $past(wdata[CFG_W-1:0]));
endmodule

// File: rtl/trsel_unit.sv
module trsel_unit
  import trsel_pkg::*;
#(
  parameter int NG = NGRP,
  parameter int MW = MASK_W
) (
  input  logic [GRP_W-1:0]       grp,
  input  logic [MW-1:0]          mask,
  input  logic [NG-1:0][MW-1:0]  res,
  output logic                   hit
);
  localparam int SW = $clog2(NG);
  logic [MW-1:0] vec;

  always_comb begin
    vec = '0;
    if (int'(grp) < NG) vec = res[grp[SW-1:0]];
    hit = |(vec & mask);
  end
endmodule

// File: rtl/trsel_pair.sv
module trsel_pair
  import trsel_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic [2:0] code,
  output logic       evt
);
  always_comb begin
    unique case (pair_code_e'(code))
      PC_AND:    evt = a & b;
      PC_NAANDB: evt = !a & b;
      PC_NOR:    evt = !a & !b;
      PC_NAND:   evt = !a | !b;
      PC_NAORB:  evt = !a | b;
      PC_OR:     evt = a | b;
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/trsel_bank.sv
module trsel_bank
  import trsel_pkg::*;
#(
  parameter int NSEL = 32,
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter logic [AW-1:0] BASE = 12'h200,
  localparam int NPAIR = NSEL/2 - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              trace_busy,
  output logic [DW-1:0]     bus_rdata,
  input  logic [EXT_W-1:0]  ext_in,
  input  logic [CMP_W-1:0]  core_cmp,
  input  logic [CNT_W-1:0]  cnt_zero,
  input  logic [SEQ_W-1:0]  seq_state,
  input  logic [SHOT_W-1:0] shot_ctl,
  input  logic [ADR_W-1:0]  addr_match,
  input  logic [RNG_W-1:0]  range_match,
  input  logic [CTX_W-1:0]  ctx_match,
  input  logic [VCTX_W-1:0] vctx_match,
  output logic [NPAIR-1:0]  pair_evt
);
  logic [(NSEL-2)*CFG_W-1:0]   cfg_flat;
  logic [NGRP-1:0][MASK_W-1:0] res;
  logic [CFG_W-1:0]            cfg [2:NSEL-1];
  logic                        raw [2:NSEL-1];
  logic [NPAIR-1:0]            evt_n;

  trsel_regs #(.NSEL(NSEL), .AW(AW), .DW(DW), .BASE(BASE)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .busy(trace_busy), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .cfg_flat(cfg_flat));

  // resource groups, zero-padded to the mask width
  always_comb begin
    res = '0;
    res[0][EXT_W-1:0]          = ext_in;
    res[1][CMP_W-1:0]          = core_cmp;
    res[2][CNT_W-1:0]          = cnt_zero;
    res[2][CNT_W+SEQ_W-1:CNT_W] = seq_state;
    res[3][SHOT_W-1:0]         = shot_ctl;
    res[4][ADR_W-1:0]          = addr_match;
    res[5][RNG_W-1:0]          = range_match;
    res[6][CTX_W-1:0]          = ctx_match;
    res[7][VCTX_W-1:0]         = vctx_match;
  end

  for (genvar s = 2; s < NSEL; s++) begin : g_sel
    assign cfg[s] = cfg_flat[(s-2)*CFG_W +: CFG_W];
    trsel_unit #(.NG(NGRP), .MW(MASK_W)) u_unit (
      .grp(cfg[s][GRP_LO +: GRP_W]), .mask(cfg[s][MASK_W-1:0]),
      .res(res), .hit(raw[s]));

    assert_rsv_grp_R8: assert property (@(posedge clk) disable iff (rst)
      (int'(cfg[s][GRP_LO +: GRP_W]) >= NGRP) |-> !raw[s]);
    assert_zero_mask_R7: assert property (@(posedge clk) disable iff (rst)
      (cfg[s][MASK_W-1:0] == '0) |-> !raw[s]);
  end

  for (genvar p = 1; p <= NPAIR; p++) begin : g_pair
    logic [2:0] code;
    assign code = {cfg[2*p][PINV_B], cfg[2*p][INV_B], cfg[2*p+1][INV_B]};
    trsel_pair u_pair (.a(raw[2*p]), .b(raw[2*p+1]), .code(code), .evt(evt_n[p-1]));

    assert_rsv_code_R10: assert property (@(posedge clk) disable iff (rst)
      (code == 3'b001 || code == 3'b110) |=> !pair_evt[p-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) pair_evt <= '0;
    else     pair_evt <= evt_n;
  end
endmodule

// File: tb/sim_trsel_bank.sv
module sim_trsel_bank;
  logic clk = 0, rst = 1;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 0, trace_busy = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] ext_in = '0, cnt_zero = '0, seq_state = '0;
  logic [7:0] core_cmp = '0, shot_ctl = '0, range_match = '0, ctx_match = '0, vctx_match = '0;
  logic [15:0] addr_match = '0;
  logic [14:0] pair_evt;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [21:0] sh [32];

  always #10 clk = ~clk;

  trsel_bank u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .trace_busy(trace_busy), .bus_rdata(bus_rdata),
    .ext_in(ext_in), .core_cmp(core_cmp), .cnt_zero(cnt_zero), .seq_state(seq_state),
    .shot_ctl(shot_ctl), .addr_match(addr_match), .range_match(range_match),
    .ctx_match(ctx_match), .vctx_match(vctx_match), .pair_evt(pair_evt));

  function automatic bit addr_ok(logic [11:0] a);
    return a[1:0] == 2'b00 && a[11:7] == 5'b00100 && a[6:2] >= 5'd2;
  endfunction

  function automatic logic sel_raw(logic [21:0] c);
    logic [15:0] v;
    case (c[19:16])
      4'd0: v = {12'b0, ext_in};
      4'd1: v = {8'b0, core_cmp};
      4'd2: v = {8'b0, seq_state, cnt_zero};
      4'd3: v = {8'b0, shot_ctl};
      4'd4: v = addr_match;
      4'd5: v = {8'b0, range_match};
      4'd6: v = {8'b0, ctx_match};
      4'd7: v = {8'b0, vctx_match};
      default: v = '0;
    endcase
    return |(v & c[15:0]);
  endfunction

  function automatic logic pair_exp(logic a, logic b, logic [2:0] code);
    case (code)
      3'b000: return a & b;
      3'b010: return !a & b;
      3'b011: return !a & !b;
      3'b100: return !a | !b;
      3'b101: return !a | b;
      3'b111: return a | b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [14:0] model_all();
    logic [14:0] r;
    for (int j = 0; j < 15; j++) begin
      int e = 2*j + 2;
      r[j] = pair_exp(sel_raw(sh[e]), sel_raw(sh[e+1]), {sh[e][21], sh[e][20], sh[e+1][20]});
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write at the coming edge; caller is at a falling edge
  task automatic wr(logic [11:0] a, logic [31:0] d, bit busy);
    bus_addr = a; bus_wdata = d; bus_wr = 1; trace_busy = busy;
    @(negedge clk);
    bus_wr = 0; trace_busy = 0;
    if (!busy && addr_ok(a)) sh[a[6:2]] = d[21:0];
  endtask

  task automatic rd_chk(string req, logic [11:0] a);
    bus_addr = a;
    @(negedge clk);
    chk(req, bus_rdata, addr_ok(a) ? {10'b0, sh[a[6:2]]} : 32'h0);
  endtask

  task automatic step_chk(string req);
    @(negedge clk);
    chk(req, {17'b0, pair_evt}, {17'b0, model_all()});
  endtask

  function automatic logic [11:0] ra(int n);
    return 12'h200 + 12'(4*n);
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 32; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 pair_evt", {17'b0, pair_evt}, 32'h0);
    rd_chk("R1 reg2", ra(2));
    rd_chk("R1 reg31", ra(31));

    // R2/R3: address map and reserved bits
    wr(ra(2), 32'hFFC0_1234, 0);
    rd_chk("R3 reserved bits zero", ra(2));
    chk("R3 value", bus_rdata, 32'h0000_1234);
    wr(ra(1), 32'h0000_00FF, 0);
    rd_chk("R2 selector 1 reads zero", ra(1));
    wr(ra(2) + 12'd1, 32'h0000_5555, 0);
    rd_chk("R2 misaligned write ignored", ra(2));
    wr(12'h100 + 12'd8, 32'h0000_7777, 0);
    rd_chk("R2 outside window ignored", ra(2));

    // R4: busy write dropped
    wr(ra(3), 32'h0007_ABCD, 1);
    rd_chk("R4 busy write dropped", ra(3));
    chk("R4 still zero", bus_rdata, 32'h0);

    // R5/R12/R11: pair 1 = A|B, A = ext_in[0], B = reserved group
    wr(ra(2), 32'h0030_0001, 0);
    wr(ra(3), 32'h0018_0001, 0);
    ext_in = 4'h1;
    #1 chk("R11 output not yet updated", {31'b0, pair_evt[0]}, 32'h0);
    step_chk("R11 output after edge");
    chk("R12 pair1 in bit0", {31'b0, pair_evt[0]}, 32'h1);
    ext_in = 4'h0;
    step_chk("R8 reserved group false");

    // R6: group 2 counter/sequencer split, pair 2 = A&B
    wr(ra(4), 32'h0002_0010, 0);
    wr(ra(5), 32'h0002_0002, 0);
    for (int k = 0; k < 8; k++) begin
      {seq_state, cnt_zero} = 8'(1 << k);
      step_chk("R6 group2 bit walk");
    end
    seq_state = 4'h1; cnt_zero = 4'h2;
    step_chk("R6 both selected");
    chk("R6 pair2 high", {31'b0, pair_evt[1]}, 32'h1);

    // R7: mask bits above group width ignored
    wr(ra(6), 32'h0030_FFF0, 0);
    wr(ra(7), 32'h0010_FF00, 0);
    ext_in = 4'hF; core_cmp = 8'hFF;
    step_chk("R7 upper mask ignored");
    chk("R7 pair3 low", {31'b0, pair_evt[2]}, 32'h0);

    // R9/R10: every code against every A,B; odd bit21 ignored
    for (int code = 0; code < 8; code++) begin
      for (int ab = 0; ab < 4; ab++) begin
        wr(ra(8), {10'b0, 2'(code >> 1), 4'd0, 16'h0001}, 0);
        wr(ra(9), {10'b0, 1'b1, 1'(code), 4'd0, 16'h0002}, 0);
        ext_in = {2'b0, 1'(ab >> 1), 1'(ab)};
        step_chk((code == 1 || code == 6) ? "R10 reserved code" : "R9 code table");
      end
    end

    // R5/R11/R12: random configuration and inputs
    for (int it = 0; it < 400; it++) begin
      logic [31:0] d = $urandom;
      int n = 2 + int'($urandom % 30);
      logic [11:0] a = ra(n);
      d[19:16] = 4'($urandom % 10);
      if ($urandom % 8 == 0) a = 12'($urandom);
      wr(a, d, ($urandom % 5) == 0);
      {ext_in, core_cmp, cnt_zero, seq_state} = 24'($urandom);
      {shot_ctl, addr_match, range_match} = $urandom;
      {ctx_match, vctx_match} = 16'($urandom);
      step_chk("R5 random");
      if (it % 20 == 0) rd_chk("R3 random readback", ra(n));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule